// File: doc/BRIEF.md
# DMA Expansion I/O Cycle Decoder

This block sits in a DMA-capable agent on a PCI-style bus in a scheme where the system DMA controller performs each transfer as two separate bus cycles. The controller moves memory data itself; this block watches only the I/O half of each transfer. It samples the address, command and byte-enable bus at the start of every bus cycle, and acts on a cycle only when the agent's own grant input is active at that moment.

The I/O address carries the meaning of a DMA I/O cycle. Two fixed addresses select a normal transfer and two select a verify transfer. Address bit 2 marks the final transfer of the current buffer. For a recognised cycle the block asserts a DMA acknowledge toward a local I/O DMA device. During the data phase it pulses a read or write strobe, and it returns device data on the lowest byte lanes only. The acknowledge is removed in the same cycle that grant goes inactive, so single-transfer mode works even when the device keeps its request asserted.

Top module: `dmaio_decoder`

## Requirements
- R1: After reset, dack_n, dev_rd_n and dev_wr_n are high, and tc, is_verify, proto_err and ad_oe are low.
- R2: An address phase is the first clock with frame_n low after a clock with frame_n high. At an address phase, AD = 32'h00 decodes as normal with terminal count clear, 32'h04 as normal with terminal count set, 32'hC0 as verify with terminal count clear, and 32'hC4 as verify with terminal count set. Any other address, or any command other than I/O read (cbe_n = 4'b0010) or I/O write (4'b0011), is ignored.
- R3: A cycle is recognised only if gnt_n is low at its address phase. Without grant, a matching address has no effect on any output.
- R4: dack_n goes low in the clock after a recognised address phase. It stays low while gnt_n stays low, and it goes high in the same cycle that gnt_n goes high, with no clock edge in between.
- R5: tc equals AD[2] of the recognised cycle whenever dack_n is low, and is low otherwise.
- R6: In a normal read, dev_rd_n is low during data-phase clocks with irdy_n low. ad_oe is high during the data phase, and ad_out carries dev_rdata on its low lanes.
- R7: In a normal write, dev_wr_n is low during data-phase clocks with irdy_n low, and dev_wdata presents the low lanes of AD.
- R8: A verify cycle asserts dack_n, tc (per R5) and is_verify. It drives neither strobe, and during its data phase ad_oe is high with ad_out all zero.
- R9: An I/O write to a verify address while granted raises proto_err for exactly the one clock after the address phase. It produces no acknowledge and no strobe.
- R10: A byte port (PORT_BYTES = 1) drives only ad_out[7:0], and a word port drives only ad_out[15:0]. Higher lanes are always zero, and ad_out is zero whenever ad_oe is low.
- R11: The data phase ends at the clock where frame_n is high and irdy_n is low. Strobes and ad_oe stay inactive from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Bus cycle framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Address/data bus as sampled |
| cbe_n | input | 4 | Command / byte enables, active low |
| gnt_n | input | 1 | This agent's DMA grant, active low |
| dev_rdata | input | 8*PORT_BYTES | Read data from the local device |
| dack_n | output | 1 | DMA acknowledge to the local device, active low |
| dev_rd_n | output | 1 | Read strobe to the device, active low |
| dev_wr_n | output | 1 | Write strobe to the device, active low |
| tc | output | 1 | Terminal count to the device |
| is_verify | output | 1 | Current cycle is a verify transfer |
| proto_err | output | 1 | Write-to-verify-address pulse |
| dev_wdata | output | 8*PORT_BYTES | Write data toward the device |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Enable for ad_out |

## Verification
The hardest case to reach is grant falling while the acknowledge is still held between cycles. At that point dack_n must rise within the same clock and not on the next edge. The stimulus reaches this case by releasing gnt_n mid-cycle after every transaction and sampling dack_n before the next edge. Random addresses, commands and grant values are mixed with directed runs of all four DMA addresses. These runs cover both directions, ungranted cycles and write-to-verify errors.

// File: rtl/dmaio_decoder.sv
module dmaio_decoder #(
  parameter int PORT_BYTES = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_n,
  input  logic                    irdy_n,
  input  logic [31:0]             ad,
  input  logic [3:0]              cbe_n,
  input  logic                    gnt_n,
  input  logic [8*PORT_BYTES-1:0] dev_rdata,
  output logic                    dack_n,
  output logic                    dev_rd_n,
  output logic                    dev_wr_n,
  output logic                    tc,
  output logic                    is_verify,
  output logic                    proto_err,
  output logic [8*PORT_BYTES-1:0] dev_wdata,
  output logic [31:0]             ad_out,
  output logic                    ad_oe
);
  localparam int DW = 8 * PORT_BYTES;
  localparam logic [3:0] CMD_IORD = 4'b0010;
  localparam logic [3:0] CMD_IOWR = 4'b0011;

  logic frame_q, active_q, dack_q, tc_q, ver_q, wr_q, err_q;

  wire addr_ph  = ~frame_n & frame_q;
  wire cmd_rd   = (cbe_n == CMD_IORD);
  wire cmd_wr   = (cbe_n == CMD_IOWR);
  wire a_norm   = (ad == 32'h0000_0000) || (ad == 32'h0000_0004);
  wire a_ver    = (ad == 32'h0000_00C0) || (ad == 32'h0000_00C4);
  wire granted  = addr_ph & ~gnt_n;
  wire hit      = granted & ((a_norm & (cmd_rd | cmd_wr)) | (a_ver & cmd_rd));
  wire bad      = granted & a_ver & cmd_wr;
  wire last_dp  = active_q & frame_n & ~irdy_n;
  wire dack_on  = dack_q & ~gnt_n;
  wire dp_on    = active_q & dack_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= 1'b1;
      active_q <= 1'b0;
      dack_q   <= 1'b0;
      tc_q     <= 1'b0;
      ver_q    <= 1'b0;
      wr_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      frame_q <= frame_n;
      err_q   <= bad;
      if (hit) begin
        active_q <= 1'b1;
        dack_q   <= 1'b1;
        tc_q     <= ad[2];
        ver_q    <= a_ver;
        wr_q     <= cmd_wr;
      end else begin
        if (last_dp || gnt_n) active_q <= 1'b0;
        if (gnt_n)            dack_q   <= 1'b0;
      end
    end
  end

  assign dack_n    = ~dack_on;
  assign tc        = dack_on & tc_q;
  assign is_verify = dack_on & ver_q;
  assign proto_err = err_q;
  assign dev_rd_n  = ~(dp_on & ~irdy_n & ~ver_q & ~wr_q);
  assign dev_wr_n  = ~(dp_on & ~irdy_n & ~ver_q & wr_q);
  assign ad_oe     = dp_on & ~wr_q;
  assign dev_wdata = ad[DW-1:0];

  always_comb begin
    ad_out = '0;
    if (ad_oe && !ver_q) ad_out[DW-1:0] = dev_rdata;
  end
endmodule

module dmaio_decoder_chk #(
  parameter int PORT_BYTES = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irdy_n,
  input logic        gnt_n,
  input logic        dack_n,
  input logic        dev_rd_n,
  input logic        dev_wr_n,
  input logic        tc,
  input logic        is_verify,
  input logic        proto_err,
  input logic [31:0] ad_out,
  input logic        ad_oe
);
  localparam int DW = 8 * PORT_BYTES;

  AST_DACK_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n) !dack_n |-> !gnt_n); // R4
  AST_TC_WITH_DACK: assert property (@(posedge clk) disable iff (!rst_n) tc |-> !dack_n); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) dev_rd_n || dev_wr_n); // R6
  AST_WR_NEEDS_IRDY: assert property (@(posedge clk) disable iff (!rst_n) !dev_wr_n |-> !irdy_n); // R7
  AST_VERIFY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) is_verify |-> (dev_rd_n && dev_wr_n)); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> !proto_err); // R9
  AST_UPPER_LANES: assert property (@(posedge clk) disable iff (!rst_n) ad_out[31:DW] == '0); // R10
  AST_IDLE_LANES: assert property (@(posedge clk) disable iff (!rst_n) !ad_oe |-> ad_out == '0); // R10
endmodule

bind dmaio_decoder dmaio_decoder_chk #(.PORT_BYTES(PORT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irdy_n(irdy_n), .gnt_n(gnt_n), .dack_n(dack_n),
  .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .tc(tc), .is_verify(is_verify),
  .proto_err(proto_err), .ad_out(ad_out), .ad_oe(ad_oe)
);

// File: tb/sim_dmaio_decoder.sv
module sim_dmaio_decoder;
  localparam int PB = 1;
  localparam int DW = 8 * PB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, gnt_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0] cbe_n = 4'hF;
  logic [DW-1:0] dev_rdata = '0;
  logic dack_n, dev_rd_n, dev_wr_n, tc, is_verify, proto_err, ad_oe;
  logic [DW-1:0] dev_wdata;
  logic [31:0] ad_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmaio_decoder #(.PORT_BYTES(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
    .cbe_n(cbe_n), .gnt_n(gnt_n), .dev_rdata(dev_rdata), .dack_n(dack_n),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .tc(tc), .is_verify(is_verify),
    .proto_err(proto_err), .dev_wdata(dev_wdata), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_norm(input logic [31:0] a);
    return a == 32'h0 || a == 32'h4;
  endfunction
  function automatic bit is_ver(input logic [31:0] a);
    return a == 32'hC0 || a == 32'hC4;
  endfunction

  task automatic xact(input logic [31:0] addr, input logic [3:0] cmd, input logic g,
                      input logic [31:0] wdat, input logic [DW-1:0] rdat);
    bit rd, wr, hit, err, ver;
    rd  = (cmd == 4'b0010);
    wr  = (cmd == 4'b0011);
    ver = is_ver(addr);
    hit = !g && ((is_norm(addr) && (rd || wr)) || (ver && rd));
    err = !g && ver && wr;
    @(negedge clk);
    gnt_n = g; frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; ad = wdat; dev_rdata = rdat; cbe_n = 4'hE;
    #1;
    chk("R2/R3/R4 dack", {31'b0, dack_n}, {31'b0, !hit});
    chk("R5 tc", {31'b0, tc}, {31'b0, hit && addr[2]});
    chk("R8 verify", {31'b0, is_verify}, {31'b0, hit && ver});
    chk("R6 rd strobe", {31'b0, dev_rd_n}, {31'b0, !(hit && !ver && rd)});
    chk("R7 wr strobe", {31'b0, dev_wr_n}, {31'b0, !(hit && wr)});
    chk("R6/R8 ad_oe", {31'b0, ad_oe}, {31'b0, hit && rd});
    chk("R6/R8/R10 ad_out", ad_out, (hit && rd && !ver) ? {{(32-DW){1'b0}}, rdat} : 32'h0);
    if (hit && wr) chk("R7 wdata", {{(32-DW){1'b0}}, dev_wdata}, {{(32-DW){1'b0}}, wdat[DW-1:0]});
    chk("R9 err", {31'b0, proto_err}, {31'b0, err});
    @(negedge clk);
    irdy_n = 1'b1; ad = '0;
    #1;
    chk("R11 rd idle", {31'b0, dev_rd_n}, 32'h1);
    chk("R11 wr idle", {31'b0, dev_wr_n}, 32'h1);
    chk("R11 oe idle", {31'b0, ad_oe}, 32'h0);
    chk("R9 err one clock", {31'b0, proto_err}, 32'h0);
    chk("R4 dack held", {31'b0, dack_n}, {31'b0, !hit});
    gnt_n = 1'b1;
    #1;
    chk("R4 dack drop same cycle", {31'b0, dack_n}, 32'h1);
    chk("R5 tc drop", {31'b0, tc}, 32'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [8];
    logic [3:0] cmds [4];
    void'($urandom(32'd1234));
    addrs = '{32'h0, 32'h4, 32'hC0, 32'hC4, 32'h8, 32'hC8, 32'h100, 32'h1004};
    cmds  = '{4'b0010, 4'b0011, 4'b0110, 4'b0111};
    #1;
    chk("R1 dack", {31'b0, dack_n}, 32'h1);
    chk("R1 rd", {31'b0, dev_rd_n}, 32'h1);
    chk("R1 wr", {31'b0, dev_wr_n}, 32'h1);
    chk("R1 flags", {28'b0, tc, is_verify, proto_err, ad_oe}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      xact(addrs[i], 4'b0010, 1'b0, 32'hFFFF_FF00 | i, 8'hA0 + 8'(i));
      xact(addrs[i], 4'b0011, 1'b0, 32'h1234_5600 | i, 8'h55);
      xact(addrs[i], 4'b0010, 1'b1, 32'h0, 8'h77);
    end
    xact(32'h0, 4'b0110, 1'b0, 32'h0, 8'h11);
    xact(32'h104, 4'b0010, 1'b0, 32'h0, 8'h22);
    for (int i = 0; i < 150; i++)
      xact(addrs[$urandom_range(7)], cmds[$urandom_range(3)], 1'($urandom_range(1)),
           $urandom, DW'($urandom));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule